// File: doc/BRIEF.md
# One-Time-Programmable Memory Burn Sequencer

This controller writes a complete image into a 16-bit one-time-programmable memory. After a start pulse it asks for the elevated core and programming supply levels and walks the whole array three times. The first walk gives every word a single program pulse and reads nothing back. The second walk reads each word. A word that reads wrong gets another pulse and is read again, up to a fixed number of retries. Once every word has verified, both supply requests drop back to nominal. A third walk then reads the whole array and compares it with the image.

The block drives the memory address, the write data, and the active-low chip-select, read-enable and program strobes. It also drives two level requests for the supplies. Expected data comes from an image port that is indexed by the same address. All timing is counted in clock cycles. The counts come from the clock rate in MHz and from the pulse, setup, hold and read-access times given as parameters. When the sequence ends, `done` rises, `pass` gives the outcome and `fail_addr` names the word that stopped it.

Top module: `otp_burn_seq`

## Requirements
- R1: A start pulse raises `vcc_hi` and `vpp_hi`. Both stay high for at least SETUP_US*CLK_MHZ cycles before the first program pulse, and both are high during every program pulse.
- R2: Every program pulse holds `mem_pgm_n` low for exactly PULSE_US*CLK_MHZ consecutive cycles.
- R3: The first walk gives exactly one pulse to each address, in ascending order from 0. `mem_oe_n` stays high until that walk has ended.
- R4: In the second walk each word is read. A mismatch against `img_data` triggers another pulse followed by a new read. A word that needs k pulses in total (k from 1 to 11) receives exactly k.
- R5: If a word still mismatches after RETRY_MAX (10) retry pulses, the sequence stops at once. It reports `done`=1, `pass`=0 and `fail_addr` equal to that word, and both supply requests go low. Later words keep their single first-walk pulse.
- R6: A read result is used only after `mem_oe_n` has been low, with the address unchanged, for ceil(VERIFY_NS*CLK_MHZ/1000) cycles.
- R7: Before each pulse, the address, data, read-enable (high) and supply levels are stable for at least SETUP_US*CLK_MHZ cycles. `mem_d` equals the image word for the current address. After each pulse, the address holds and `mem_oe_n` stays high for at least HOLD_US*CLK_MHZ cycles.
- R8: After the second walk, both supply requests are low and every address is read and compared. The first mismatch ends the sequence with `pass`=0 and `fail_addr` equal to the lowest mismatching address. If every word matches, `pass`=1.
- R9: A start pulse while `busy` is high has no effect on the sequence in progress.
- R10: `done`, `pass` and `fail_addr` hold their values until the next start pulse.
- R11: After reset, `busy` and `done` are 0, all three strobes are high and both supply requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a burn |
| img_data | input | DW | Image word for `addr` |
| mem_q | input | DW | Read data from the memory |
| addr | output | AW | Address to the memory and to the image port |
| mem_d | output | DW | Write data to the memory |
| mem_ce_n | output | 1 | Chip select, low while busy |
| mem_oe_n | output | 1 | Read enable, active low |
| mem_pgm_n | output | 1 | Program strobe, active low |
| vcc_hi | output | 1 | Request for the elevated core supply |
| vpp_hi | output | 1 | Request for the elevated programming supply |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished, held until the next start |
| pass | output | 1 | Outcome when done, 1 means success |
| fail_addr | output | AW | Word that caused failure, 0 on success |

## Verification
Strobe timing is a count of cycles rather than a single due time. A monitor samples every falling edge and measures pulse length, the quiet time before each pulse and the hold time after it in whole cycles. The memory model returns inverted data until read-enable has been low at a steady address for the required number of cycles. A read taken even one cycle early therefore shows up as extra pulses in the per-word pulse counts. `done` is due on the edge that ends the last compare, so the bench polls it on each falling edge and checks `pass` and `fail_addr` on the same edge. Fifty cycles later it checks that all three still hold.

// File: rtl/otp_burn_seq.sv
module otp_burn_seq #(
  parameter int WORDS     = 65536,
  parameter int DW        = 16,
  parameter int AW        = $clog2(WORDS),
  parameter int CLK_MHZ   = 50,
  parameter int PULSE_US  = 100,
  parameter int SETUP_US  = 2,
  parameter int HOLD_US   = 2,
  parameter int VERIFY_NS = 150,
  parameter int RETRY_MAX = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] img_data,
  input  logic [DW-1:0] mem_q,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] mem_d,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_pgm_n,
  output logic          vcc_hi,
  output logic          vpp_hi,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic [AW-1:0] fail_addr
);

  localparam int PULSE_CYC = CLK_MHZ * PULSE_US;
  localparam int SETUP_CYC = CLK_MHZ * SETUP_US;
  localparam int HOLD_CYC  = CLK_MHZ * HOLD_US;
  localparam int VER_RAW   = (CLK_MHZ * VERIFY_NS + 999) / 1000;
  localparam int VER_CYC   = (VER_RAW < 1) ? 1 : VER_RAW;
  localparam int TW        = $clog2(PULSE_CYC + SETUP_CYC + HOLD_CYC + VER_CYC + 1);
  localparam int RW        = $clog2(RETRY_MAX + 1);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RAMP, S_SETUP, S_PULSE, S_HOLD, S_VERIFY, S_LOWER, S_READ
  } st_t;

  st_t           st;
  logic [TW-1:0] tmr, lim;
  logic [RW-1:0] retry;
  logic          second;
  logic          tick, match;

  always_comb begin
    case (st)
      S_RAMP, S_SETUP, S_LOWER: lim = TW'(SETUP_CYC - 1);
      S_PULSE:                  lim = TW'(PULSE_CYC - 1);
      S_HOLD:                   lim = TW'(HOLD_CYC - 1);
      S_VERIFY, S_READ:         lim = TW'(VER_CYC - 1);
      default:                  lim = '0;
    endcase
  end

  assign tick      = (tmr == lim);
  assign match     = (mem_q == img_data);
  assign busy      = (st != S_IDLE);
  assign mem_ce_n  = !busy;
  assign mem_oe_n  = !(st == S_VERIFY || st == S_READ);
  assign mem_pgm_n = (st != S_PULSE);
  assign vcc_hi    = busy && st != S_LOWER && st != S_READ;
  assign vpp_hi    = vcc_hi;
  assign mem_d     = img_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tmr       <= '0;
      addr      <= '0;
      retry     <= '0;
      second    <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail_addr <= '0;
    end else begin
      tmr <= tick ? '0 : tmr + 1'b1;
      case (st)
        S_IDLE: if (start) begin
          st        <= S_RAMP;
          addr      <= '0;
          retry     <= '0;
          second    <= 1'b0;
          done      <= 1'b0;
          pass      <= 1'b0;
          fail_addr <= '0;
        end
        S_RAMP:  if (tick) st <= S_SETUP;
        S_SETUP: if (tick) st <= S_PULSE;
        S_PULSE: if (tick) st <= S_HOLD;
        S_HOLD: if (tick) begin
          if (second) st <= S_VERIFY;
          else if (addr == LAST) begin
            addr   <= '0;
            second <= 1'b1;
            st     <= S_VERIFY;
          end else begin
            addr <= addr + 1'b1;
            st   <= S_SETUP;
          end
        end
        S_VERIFY: if (tick) begin
          if (match) begin
            retry <= '0;
            if (addr == LAST) begin
              addr <= '0;
              st   <= S_LOWER;
            end else addr <= addr + 1'b1;
          end else if (retry == RW'(RETRY_MAX)) begin
            st        <= S_IDLE;
            done      <= 1'b1;
            fail_addr <= addr;
          end else begin
            retry <= retry + 1'b1;
            st    <= S_SETUP;
          end
        end
        S_LOWER: if (tick) st <= S_READ;
        S_READ: if (tick) begin
          if (!match) begin
            st        <= S_IDLE;
            done      <= 1'b1;
            fail_addr <= addr;
          end else if (addr == LAST) begin
            st   <= S_IDLE;
            done <= 1'b1;
            pass <= 1'b1;
          end else addr <= addr + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [TW-1:0] plen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) plen <= '0;
    else        plen <= !mem_pgm_n ? plen + 1'b1 : '0;
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_pgm_n) |-> plen == TW'(PULSE_CYC)); // R2
  AST_SUPPLY_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_pgm_n |-> (vcc_hi && vpp_hi)); // R1
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_pgm_n |=> $stable(addr)); // R7
  AST_RETRY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    retry <= RW'(RETRY_MAX)); // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done)); // R9

endmodule

// File: tb/otp_burn_seq_tb_top.sv
module otp_burn_seq_tb_top;
  localparam int N   = 8;
  localparam int AW  = 3;
  localparam int DW  = 16;
  localparam int MHZ = 50;
  localparam int P   = MHZ * 2;
  localparam int S   = MHZ * 1;
  localparam int H   = MHZ * 1;
  localparam int V   = (MHZ * 150 + 999) / 1000;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] addr, fail_addr;
  logic [DW-1:0] mem_d, mem_q, img_data;
  logic mem_ce_n, mem_oe_n, mem_pgm_n, vcc_hi, vpp_hi, busy, done, pass;

  logic [DW-1:0] img [N];
  logic [DW-1:0] stored [N];
  int  need [N];
  int  pcnt [N];
  bit  corrupt [N];
  bit  nomread [N];
  int  total = 0, fails = 0, gcyc = 0;
  int  pseq, order_err, width_err, setup_err, hold_err;
  int  plen, quiet, post, oe_age;
  bit  in_hold, oe_seen, last_pgm, q_vcc;
  logic [AW-1:0] q_addr, hold_addr, age_addr;
  logic [DW-1:0] rd_word;

  always #10 clk = ~clk;

  otp_burn_seq #(.WORDS(N), .DW(DW), .AW(AW), .CLK_MHZ(MHZ), .PULSE_US(2),
    .SETUP_US(1), .HOLD_US(1), .VERIFY_NS(150), .RETRY_MAX(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .img_data(img_data), .mem_q(mem_q),
    .addr(addr), .mem_d(mem_d), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_pgm_n(mem_pgm_n), .vcc_hi(vcc_hi), .vpp_hi(vpp_hi), .busy(busy),
    .done(done), .pass(pass), .fail_addr(fail_addr));

  assign img_data = img[addr];
  assign rd_word  = stored[addr] ^ ((!vcc_hi && corrupt[addr]) ? 16'h0100 : 16'h0000);
  assign mem_q    = (!mem_ce_n && !mem_oe_n)
                    ? ((oe_age >= V && addr == age_addr) ? rd_word : ~rd_word) : '1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    gcyc++;
    if (rst_n) begin
      if (!mem_oe_n) begin
        if (addr == age_addr) oe_age++;
        else begin oe_age = 1; age_addr = addr; end
        oe_seen = 1;
        if (!vcc_hi) nomread[addr] = 1;
      end else oe_age = 0;
      if (!mem_pgm_n && last_pgm) begin
        if (quiet < S || !vcc_hi || !vpp_hi || mem_ce_n || mem_d != img[addr]) setup_err++;
        if (pseq < N) begin
          if (addr != AW'(pseq) || oe_seen) order_err++;
          pseq++;
        end
        pcnt[addr]++;
        if (vcc_hi && vpp_hi && !mem_ce_n && pcnt[addr] >= need[addr]) stored[addr] = mem_d;
      end
      if (addr != q_addr || vcc_hi != q_vcc) quiet = mem_oe_n ? 1 : 0;
      else if (!mem_oe_n) quiet = 0;
      else quiet++;
      if (in_hold) begin
        if (addr != hold_addr || !mem_oe_n) begin
          if (post < H) hold_err++;
          in_hold = 0;
        end else post++;
      end
      if (!mem_pgm_n) plen++;
      else if (!last_pgm) begin
        if (plen != P) width_err++;
        plen = 0; in_hold = 1; post = 1; hold_addr = addr;
      end
      last_pgm = mem_pgm_n; q_addr = addr; q_vcc = vcc_hi;
    end
  end

  task automatic predict(output bit ef, output int ea);
    ef = 0; ea = 0;
    for (int i = 0; i < N; i++) if (!ef && need[i] > 11) begin ef = 1; ea = i; end
    if (!ef) for (int i = 0; i < N; i++) if (!ef && corrupt[i]) begin ef = 1; ea = i; end
  endtask

  task automatic setup_case(input int maxneed);
    for (int i = 0; i < N; i++) begin
      img[i] = DW'($urandom) & 16'hFFFE;
      need[i] = 1 + ($urandom % maxneed);
      corrupt[i] = 0; stored[i] = '1; pcnt[i] = 0; nomread[i] = 0;
    end
  endtask

  task automatic run_case(input string name, input bit inject);
    bit ef, verify_fail; int ea, cyc;
    predict(ef, ea);
    verify_fail = 0;
    for (int i = 0; i < N; i++) if (need[i] > 11) verify_fail = 1;
    pseq = 0; order_err = 0; width_err = 0; setup_err = 0; hold_err = 0;
    plen = 0; oe_seen = 0; in_hold = 0; quiet = 0; last_pgm = 1;
    @(negedge clk); start = 1;
    cyc = 0;
    forever begin
      @(negedge clk); cyc++;
      start = (inject && cyc == 400);
      if (done || cyc > 30000) break;
    end
    chk(cyc <= 30000, "R8", {name, " watchdog"}, cyc, 30000);
    chk(done === 1'b1, "R8", {name, " done"}, done, 1);
    chk(pass === !ef, ef ? (verify_fail ? "R5" : "R8") : "R8", {name, " pass"}, pass, !ef);
    chk(fail_addr === AW'(ea), ef ? (verify_fail ? "R5" : "R8") : "R8", {name, " fail_addr"}, fail_addr, ea);
    chk(!vcc_hi && !vpp_hi && !busy, "R5", {name, " supplies low at end"}, vcc_hi, 0);
    for (int i = 0; i < N; i++) begin
      int e;
      if (!verify_fail || i < ea) e = need[i];
      else if (i == ea) e = 11;
      else e = 1;
      chk(pcnt[i] == e, inject ? "R9" : "R4 R6", {name, " pulse count"}, pcnt[i], e);
    end
    chk(order_err == 0, "R3", {name, " first walk order"}, order_err, 0);
    chk(width_err == 0, "R2", {name, " pulse width"}, width_err, 0);
    chk(setup_err == 0, "R1 R7", {name, " setup"}, setup_err, 0);
    chk(hold_err == 0, "R7", {name, " hold"}, hold_err, 0);
    if (!ef) for (int i = 0; i < N; i++)
      chk(nomread[i], "R8", {name, " nominal read"}, nomread[i], 1);
    repeat (50) @(negedge clk);
    chk(done && pass === !ef && fail_addr === AW'(ea), "R10", {name, " result held"}, done, 1);
  endtask

  initial begin
    void'($urandom(32'd4711));
    q_addr = '0; age_addr = '0; hold_addr = '0; q_vcc = 0; oe_age = 0; post = 0;
    setup_case(4);
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R11", "reset busy/done", busy, 0);
    chk(mem_ce_n && mem_oe_n && mem_pgm_n, "R11", "reset strobes", mem_pgm_n, 1);
    chk(!vcc_hi && !vpp_hi, "R11", "reset supplies", vcc_hi, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && mem_pgm_n, "R11", "idle after reset", busy, 0);

    setup_case(4);
    run_case("random_busy_start", 1);
    setup_case(3); need[3] = 11;
    run_case("eleven_pulses", 0);
    setup_case(3); need[2] = 12;
    run_case("retry_exhausted", 0);
    setup_case(3); corrupt[5] = 1; corrupt[6] = 1;
    run_case("readback_mismatch", 0);
    setup_case(2); need[N-1] = 12;
    run_case("last_word_fail", 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    wait (gcyc > 190000);
    total++; fails++;
    $display("FAIL R8 global watchdog: actual %0d expected %0d", gcyc, 190000);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule